// File: doc/BRIEF.md
# Debug Watch and Break Unit

This block watches a processor's instruction fetch stream and its load/store accesses and decides when to raise watchpoint and breakpoint signals for a debug system. Eight unsigned comparators test the current values against programmed references. Four of them test the instruction fetch address, two test the load/store address and two test the load/store data. Each comparator applies one of four conditions. Neighbouring comparators are grouped into pairs, and a pair can report a single comparator, a closed range or its complement. Two AND-OR structures merge the pair results into one instruction watch and one load/store watch.

Each watch channel drives a watchpoint output whenever its event occurs. Each channel also has a countdown counter, so its breakpoint can wait until the event has been seen a programmed number of times. Breakpoints and counting depend on the processor's restartable status bit. In masked mode they are held off while that bit is clear. In non-masked mode they go ahead regardless, and the debugger accepts the risk of a non-restartable state. Watchpoints are never held off. Configuration arrives as static input vectors. The counter preset is written through a per-channel load strobe.

Top module: `dbg_watch_unit`

## Requirements
- R1: Each comparator compares unsigned; its 2-bit condition code selects 0 = equal, 1 = not equal, 2 = operand greater than reference, 3 = operand less than reference. Comparators 0-3 take the fetch address, 4-5 the load/store address, 6-7 the load/store data, and comparator k uses reference bits [32k+31:32k] and condition bits [2k+1:2k].
- R2: Pair p joins comparators 2p and 2p+1 under mode bits [2p+1:2p]: 0 = off (false), 1 = first comparator alone, 2 = both true, 3 = not both true. The instruction watch (channel 0) is set when a fetch is valid and pair 0 or pair 1 is true.
- R3: With the first comparator of a pair set to greater-than (low-1) and the second to less-than (high+1), mode 2 flags low..high inclusive, and mode 3 flags every value outside that range.
- R4: The load/store watch (channel 1) is set only on a valid load/store access. It requires pair 2 (address) and pair 3 (data) to be true, where a pair in mode 0 counts as true. If both pairs are in mode 0, channel 1 never fires.
- R5: A watch event drives its watchpoint output whatever the restartable bit and the mode.
- R6: With counting enabled for a channel, its breakpoint is raised on the event that takes the count from 1 to 0. A preset of N therefore fires on the N-th event, and a preset of 0 or 1 fires on the first event. With counting disabled, every permitted event raises the breakpoint.
- R7: A count at zero stays at zero. Each further permitted event raises the breakpoint, until a reload.
- R8: In masked mode (non-masked input 0) with the restartable bit clear, no breakpoint is raised and the counters do not change.
- R9: In non-masked mode, breakpoints and counting proceed with the restartable bit clear.
- R10: The outputs are registered. They show the event of cycle t in cycle t+1 as a one-cycle pulse, and they are low in and right after reset.
- R11: A load strobe writes the preset into its counter. In that cycle an event on a counting channel neither decrements the count nor raises the breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ifetch_vld_i | input | 1 | Instruction fetch valid |
| ifetch_addr_i | input | VAL_W | Instruction fetch address |
| ls_vld_i | input | 1 | Load/store access valid |
| ls_addr_i | input | VAL_W | Load/store address |
| ls_data_i | input | VAL_W | Load/store data |
| ri_i | input | 1 | Processor state restartable |
| nonmask_i | input | 1 | 1 = non-masked mode, 0 = masked mode |
| cmp_ref_i | input | 8*VAL_W | Comparator reference values |
| cmp_cond_i | input | 16 | Comparator condition codes |
| pair_mode_i | input | 8 | Pair combine modes |
| cnt_en_i | input | 2 | Per-channel counting enable |
| cnt_load_i | input | 2 | Per-channel counter load strobe |
| cnt_preset_i | input | CNT_W | Counter preset value |
| wp_o | output | 2 | Watchpoint pulses (0 = fetch, 1 = load/store) |
| bp_o | output | 2 | Breakpoint requests (0 = fetch, 1 = load/store) |

## Verification
A wrong comparator or combine result shows up one cycle after the access as a watchpoint pulse that is present or missing on the wrong channel. A corrupted counter stays hidden until its channel's events reach it. It then shows as a breakpoint pulse that arrives early or late, or as a breakpoint that keeps firing or never fires. A counter that decrements or fires in masked mode with the restartable bit clear shows at once as a breakpoint pulse, or later as a shifted one once the bit is set. A cycle-by-cycle model of both channels tracks this over directed counts and a long randomised run.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;

    localparam int N_IADDR  = 4;
    localparam int N_LADDR  = 2;
    localparam int N_LDATA  = 2;
    localparam int NUM_CMP  = N_IADDR + N_LADDR + N_LDATA;
    localparam int NUM_PAIR = NUM_CMP / 2;
    localparam int N_IPAIR  = N_IADDR / 2;
    localparam int PAIR_LA  = N_IPAIR;
    localparam int PAIR_LD  = N_IPAIR + N_LADDR / 2;
    localparam int NUM_CH   = 2;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_NE = 2'd1,
        CMP_GT = 2'd2,
        CMP_LT = 2'd3
    } cmp_cond_e;

    typedef enum logic [1:0] {
        PAIR_OFF = 2'd0,
        PAIR_ONE = 2'd1,
        PAIR_IN  = 2'd2,
        PAIR_OUT = 2'd3
    } pair_mode_e;

    typedef struct packed {
        logic [NUM_CH-1:0] wp;
        logic [NUM_CH-1:0] bp;
    } out_regs_t;

endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
    import dbg_watch_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] ref_i,
    input  logic [1:0]   cond_i,
    output logic         hit_o
);

    always_comb begin
        unique case (cmp_cond_e'(cond_i))
            CMP_EQ:  hit_o = (val_i == ref_i);
            CMP_NE:  hit_o = (val_i != ref_i);
            CMP_GT:  hit_o = (val_i >  ref_i);
            default: hit_o = (val_i <  ref_i);
        endcase
    end

endmodule

// File: rtl/dbg_pair.sv
module dbg_pair
    import dbg_watch_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic [1:0] mode_i,
    output logic       term_o
);

    always_comb begin
        unique case (pair_mode_e'(mode_i))
            PAIR_OFF: term_o = 1'b0;
            PAIR_ONE: term_o = a_i;
            PAIR_IN:  term_o = a_i & b_i;
            default:  term_o = ~(a_i & b_i);
        endcase
    end

endmodule

// File: rtl/dbg_evcount.sv
module dbg_evcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             watch_i,
    input  logic             allow_i,
    input  logic             count_en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       fire_d;
    logic       permitted;

    assign permitted = watch_i & allow_i;

    always_comb begin
        state_d = state_q;
        fire_d  = 1'b0;
        if (load_i) begin
            state_d.cnt = preset_i;
        end
        if (!count_en_i) begin
            fire_d = permitted;
        end else if (!load_i && permitted) begin
            if (state_q.cnt <= CNT_W'(1)) begin
                fire_d      = 1'b1;
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fire_o  = fire_d;
    assign count_o = state_q.cnt;

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
    import dbg_watch_pkg::*;
#(
    parameter int VAL_W = 32,
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ifetch_vld_i,
    input  logic [VAL_W-1:0]         ifetch_addr_i,
    input  logic                     ls_vld_i,
    input  logic [VAL_W-1:0]         ls_addr_i,
    input  logic [VAL_W-1:0]         ls_data_i,
    input  logic                     ri_i,
    input  logic                     nonmask_i,
    input  logic [NUM_CMP*VAL_W-1:0] cmp_ref_i,
    input  logic [2*NUM_CMP-1:0]     cmp_cond_i,
    input  logic [2*NUM_PAIR-1:0]    pair_mode_i,
    input  logic [NUM_CH-1:0]        cnt_en_i,
    input  logic [NUM_CH-1:0]        cnt_load_i,
    input  logic [CNT_W-1:0]         cnt_preset_i,
    output logic [NUM_CH-1:0]        wp_o,
    output logic [NUM_CH-1:0]        bp_o
);

    localparam int LS_FIRST = N_IADDR;
    localparam int LD_FIRST = N_IADDR + N_LADDR;

    logic [NUM_CMP-1:0]               cmp_hit;
    logic [NUM_PAIR-1:0]              pair_term;
    logic [NUM_CH-1:0]                watch;
    logic [NUM_CH-1:0]                fire;
    logic [NUM_CH-1:0][CNT_W-1:0]     cnt_val;
    logic                             allow;
    logic                             la_off;
    logic                             ld_off;
    out_regs_t                        out_d, out_q;

    // Comparator bank: operand source chosen by position
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        logic [VAL_W-1:0] operand;
        if (g < LS_FIRST) begin : g_if
            assign operand = ifetch_addr_i;
        end else if (g < LD_FIRST) begin : g_la
            assign operand = ls_addr_i;
        end else begin : g_ld
            assign operand = ls_data_i;
        end
        dbg_cmp #(.W(VAL_W)) u_cmp (
            .val_i  (operand),
            .ref_i  (cmp_ref_i[g*VAL_W +: VAL_W]),
            .cond_i (cmp_cond_i[2*g +: 2]),
            .hit_o  (cmp_hit[g])
        );
    end

    // AND stage: comparator pairs
    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        dbg_pair u_pair (
            .a_i    (cmp_hit[2*p]),
            .b_i    (cmp_hit[2*p+1]),
            .mode_i (pair_mode_i[2*p +: 2]),
            .term_o (pair_term[p])
        );
    end

    // OR stage for fetch, qualified AND for load/store
    assign la_off = (pair_mode_i[2*PAIR_LA +: 2] == PAIR_OFF);
    assign ld_off = (pair_mode_i[2*PAIR_LD +: 2] == PAIR_OFF);

    always_comb begin
        watch[0] = ifetch_vld_i & (|pair_term[N_IPAIR-1:0]);
        watch[1] = ls_vld_i & ~(la_off & ld_off)
                 & (la_off | pair_term[PAIR_LA])
                 & (ld_off | pair_term[PAIR_LD]);
    end

    assign allow = ri_i | nonmask_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbg_evcount #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .watch_i    (watch[c]),
            .allow_i    (allow),
            .count_en_i (cnt_en_i[c]),
            .load_i     (cnt_load_i[c]),
            .preset_i   (cnt_preset_i),
            .fire_o     (fire[c]),
            .count_o    (cnt_val[c])
        );
    end

    always_comb begin
        out_d    = out_q;
        out_d.wp = watch;
        out_d.bp = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wp_o = out_q.wp;
    assign bp_o = out_q.bp;

endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk #(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ifetch_vld_i,
    input logic                 ls_vld_i,
    input logic                 ri_i,
    input logic                 nonmask_i,
    input logic [1:0]           cnt_load_i,
    input logic [CNT_W-1:0]     cnt_preset_i,
    input logic [1:0][CNT_W-1:0] cnt_val,
    input logic [1:0]           wp_o,
    input logic [1:0]           bp_o
);

    a_r2_fetch_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ifetch_vld_i |=> !wp_o[0]);

    a_r4_ls_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_vld_i |=> !wp_o[1]);

    a_r6_bp_with_wp0: assert property (@(posedge clk) disable iff (!rst_n)
        bp_o[0] |-> wp_o[0]);

    a_r6_bp_with_wp1: assert property (@(posedge clk) disable iff (!rst_n)
        bp_o[1] |-> wp_o[1]);

    a_r8_masked_no_bp: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonmask_i && !ri_i) |=> (bp_o == 2'b00));

    a_r8_masked_hold0: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonmask_i && !ri_i && !cnt_load_i[0]) |=> $stable(cnt_val[0]));

    a_r8_masked_hold1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonmask_i && !ri_i && !cnt_load_i[1]) |=> $stable(cnt_val[1]));

    a_r7_zero_stays0: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val[0] == '0 && !cnt_load_i[0]) |=> (cnt_val[0] == '0));

    a_r11_load0: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load_i[0] |=> (cnt_val[0] == $past(cnt_preset_i)));

    a_r11_load1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load_i[1] |=> (cnt_val[1] == $past(cnt_preset_i)));

endmodule

bind dbg_watch_unit dbg_watch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ifetch_vld_i (ifetch_vld_i),
    .ls_vld_i     (ls_vld_i),
    .ri_i         (ri_i),
    .nonmask_i    (nonmask_i),
    .cnt_load_i   (cnt_load_i),
    .cnt_preset_i (cnt_preset_i),
    .cnt_val      (cnt_val),
    .wp_o         (wp_o),
    .bp_o         (bp_o)
);

// File: tb/dbg_watch_unit_bench.sv
`timescale 1ns/1ps
module dbg_watch_unit_bench;

    localparam int VAL_W = 32;
    localparam int CNT_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               if_vld = 1'b0;
    logic [VAL_W-1:0]   if_addr = '0;
    logic               ls_vld = 1'b0;
    logic [VAL_W-1:0]   ls_addr = '0;
    logic [VAL_W-1:0]   ls_data = '0;
    logic               ri = 1'b1;
    logic               nm = 1'b0;
    logic [8*VAL_W-1:0] cref = '0;
    logic [15:0]        ccond = '0;
    logic [7:0]         pmode = '0;
    logic [1:0]         cnt_en = '0;
    logic [1:0]         cnt_load = '0;
    logic [CNT_W-1:0]   preset = '0;
    logic [1:0]         wp_o, bp_o;

    int checks = 0;
    int errors = 0;
    int mc [2];
    logic [1:0] exp_wp = '0;
    logic [1:0] exp_bp = '0;

    always #10 clk = ~clk;

    dbg_watch_unit #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_dbg_watch_unit (
        .clk(clk), .rst_n(rst_n),
        .ifetch_vld_i(if_vld), .ifetch_addr_i(if_addr),
        .ls_vld_i(ls_vld), .ls_addr_i(ls_addr), .ls_data_i(ls_data),
        .ri_i(ri), .nonmask_i(nm),
        .cmp_ref_i(cref), .cmp_cond_i(ccond), .pair_mode_i(pmode),
        .cnt_en_i(cnt_en), .cnt_load_i(cnt_load), .cnt_preset_i(preset),
        .wp_o(wp_o), .bp_o(bp_o)
    );

    // ---------------- reference model ----------------
    function automatic bit m_cmp(int k);
        logic [31:0] v, r;
        v = (k < 4) ? if_addr : (k < 6) ? ls_addr : ls_data;
        r = cref[k*32 +: 32];
        case (ccond[k*2 +: 2])
            2'd0: return v == r;
            2'd1: return v != r;
            2'd2: return v > r;
            default: return v < r;
        endcase
    endfunction

    function automatic bit m_pair(int p);
        bit a, b;
        a = m_cmp(2*p);
        b = m_cmp(2*p+1);
        case (pmode[2*p +: 2])
            2'd0: return 1'b0;
            2'd1: return a;
            2'd2: return a && b;
            default: return !(a && b);
        endcase
    endfunction

    task automatic model_tick();
        bit w [2];
        bit allow;
        logic [1:0] am, dm;
        am = pmode[5:4];
        dm = pmode[7:6];
        w[0] = if_vld && (m_pair(0) || m_pair(1));
        w[1] = ls_vld && !(am == 0 && dm == 0) && (am == 0 || m_pair(2)) && (dm == 0 || m_pair(3));
        allow = ri || nm;
        for (int k = 0; k < 2; k++) begin
            exp_wp[k] = w[k];
            exp_bp[k] = 1'b0;
            if (!cnt_en[k]) exp_bp[k] = w[k] && allow;
            if (cnt_load[k]) begin
                mc[k] = int'(preset);
            end else if (cnt_en[k] && w[k] && allow) begin
                if (mc[k] <= 1) begin
                    exp_bp[k] = 1'b1;
                    mc[k] = 0;
                end else begin
                    mc[k] = mc[k] - 1;
                end
            end
        end
    endtask

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk(tag, "wp", wp_o, exp_wp);
        chk(tag, "bp", bp_o, exp_bp);
    endtask

    task automatic hand(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic clear_cfg();
        cref = '0; ccond = '0; pmode = '0; cnt_en = '0; cnt_load = '0;
        ri = 1'b1; nm = 1'b0; if_vld = 1'b0; ls_vld = 1'b0;
    endtask

    task automatic set_cmp(int k, logic [31:0] r, logic [1:0] c);
        cref[k*32 +: 32] = r;
        ccond[k*2 +: 2] = c;
    endtask

    task automatic fetch(logic [31:0] a, string tag);
        if_vld = 1'b1; if_addr = a;
        step(tag);
        if_vld = 1'b0;
    endtask

    task automatic load0(logic [CNT_W-1:0] v, string tag);
        preset = v; cnt_load = 2'b01;
        step(tag);
        cnt_load = 2'b00;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int vals [3];
        bit e;
        mc[0] = 0; mc[1] = 0;
        repeat (3) @(negedge clk);
        chk("R10", "reset wp", wp_o, 2'b00);
        chk("R10", "reset bp", bp_o, 2'b00);
        rst_n = 1'b1;
        step("R10");

        // R1: each condition on comparator 0
        vals[0] = 99; vals[1] = 100; vals[2] = 101;
        for (int c = 0; c < 4; c++) begin
            clear_cfg();
            set_cmp(0, 100, 2'(c));
            pmode[1:0] = 2'd1;
            for (int i = 0; i < 3; i++) begin
                fetch(vals[i], "R1");
                e = (c == 0) ? (vals[i] == 100) : (c == 1) ? (vals[i] != 100) :
                    (c == 2) ? (vals[i] > 100) : (vals[i] < 100);
                hand("R1", "wp0", wp_o[0], e);
            end
        end

        // R3: inclusive range 200..300 on pair 1 and its complement
        vals[0] = 199;
        for (int m = 2; m < 4; m++) begin
            clear_cfg();
            set_cmp(2, 199, 2'd2);
            set_cmp(3, 301, 2'd3);
            pmode[3:2] = 2'(m);
            fetch(199, "R3"); hand("R3", "below", wp_o[0], m == 3);
            fetch(200, "R3"); hand("R3", "low", wp_o[0], m == 2);
            fetch(300, "R3"); hand("R3", "high", wp_o[0], m == 2);
            fetch(301, "R3"); hand("R3", "above", wp_o[0], m == 3);
        end

        // R2: OR across pairs, fetch valid required
        clear_cfg();
        set_cmp(0, 5, 2'd0); set_cmp(2, 9, 2'd0);
        pmode[1:0] = 2'd1; pmode[3:2] = 2'd1;
        fetch(5, "R2"); hand("R2", "pair0", wp_o[0], 1'b1);
        fetch(9, "R2"); hand("R2", "pair1", wp_o[0], 1'b1);
        fetch(7, "R2"); hand("R2", "neither", wp_o[0], 1'b0);
        if_addr = 5; step("R2"); hand("R2", "no valid", wp_o[0], 1'b0);

        // R4: load/store address and data terms
        clear_cfg();
        set_cmp(4, 32'h40, 2'd0); set_cmp(6, 32'hAA, 2'd0);
        pmode[5:4] = 2'd1;
        ls_addr = 32'h40; ls_data = 32'h11; ls_vld = 1'b1;
        step("R4"); hand("R4", "addr only", wp_o[1], 1'b1);
        ls_vld = 1'b0; step("R4"); hand("R4", "not valid", wp_o[1], 1'b0);
        pmode[7:6] = 2'd1; ls_vld = 1'b1; ls_data = 32'hAA;
        step("R4"); hand("R4", "addr and data", wp_o[1], 1'b1);
        ls_data = 32'hAB; step("R4"); hand("R4", "data miss", wp_o[1], 1'b0);
        pmode = '0; ls_data = 32'hAA; step("R4"); hand("R4", "both off", wp_o[1], 1'b0);
        ls_vld = 1'b0;

        // R5 / R8 / R9 with counting disabled
        clear_cfg();
        set_cmp(0, 5, 2'd0); pmode[1:0] = 2'd1;
        ri = 1'b0;
        fetch(5, "R5"); hand("R5", "wp masked ri0", wp_o[0], 1'b1);
        hand("R8", "bp masked ri0", bp_o[0], 1'b0);
        nm = 1'b1;
        fetch(5, "R9"); hand("R9", "bp nonmask ri0", bp_o[0], 1'b1);
        nm = 1'b0; ri = 1'b1;
        fetch(5, "R5"); hand("R5", "bp ri1", bp_o[0], 1'b1);
        step("R10"); hand("R10", "pulse ends", bp_o[0], 1'b0);

        // R6 / R7: count to three, hold at zero, reload
        cnt_en = 2'b01;
        load0(3, "R11");
        fetch(5, "R6"); hand("R6", "ev1", bp_o[0], 1'b0);
        fetch(5, "R6"); hand("R6", "ev2", bp_o[0], 1'b0);
        fetch(5, "R6"); hand("R6", "ev3", bp_o[0], 1'b1);
        fetch(5, "R7"); hand("R7", "at zero", bp_o[0], 1'b1);
        load0(2, "R7");
        fetch(5, "R7"); hand("R7", "reload ev1", bp_o[0], 1'b0);
        fetch(5, "R7"); hand("R7", "reload ev2", bp_o[0], 1'b1);

        // R8: masked with ri clear freezes the count
        load0(2, "R8");
        ri = 1'b0;
        for (int i = 0; i < 3; i++) begin
            fetch(5, "R8"); hand("R8", "frozen", bp_o[0], 1'b0);
        end
        ri = 1'b1;
        fetch(5, "R8"); hand("R8", "resume ev1", bp_o[0], 1'b0);
        fetch(5, "R8"); hand("R8", "resume ev2", bp_o[0], 1'b1);

        // R9: non-masked counts with ri clear
        load0(2, "R9");
        ri = 1'b0; nm = 1'b1;
        fetch(5, "R9"); hand("R9", "ev1", bp_o[0], 1'b0);
        fetch(5, "R9"); hand("R9", "ev2", bp_o[0], 1'b1);
        ri = 1'b1; nm = 1'b0;

        // R11: load in the same cycle as an event
        preset = 2; cnt_load = 2'b01; if_vld = 1'b1; if_addr = 5;
        step("R11"); hand("R11", "load wins", bp_o[0], 1'b0);
        cnt_load = 2'b00; if_vld = 1'b0;
        fetch(5, "R11"); hand("R11", "after ev1", bp_o[0], 1'b0);
        fetch(5, "R11"); hand("R11", "after ev2", bp_o[0], 1'b1);

        // Randomised run against the model
        for (int blk = 0; blk < 50; blk++) begin
            for (int k = 0; k < 8; k++) set_cmp(k, $urandom_range(0, 15), 2'($urandom_range(0, 3)));
            pmode = 8'($urandom);
            cnt_en = 2'($urandom);
            nm = ($urandom_range(0, 3) == 0);
            for (int i = 0; i < 40; i++) begin
                if_vld = 1'($urandom);
                ls_vld = 1'($urandom);
                if_addr = $urandom_range(0, 15);
                ls_addr = $urandom_range(0, 15);
                ls_data = $urandom_range(0, 15);
                ri = ($urandom_range(0, 3) != 0);
                cnt_load = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
                preset = CNT_W'($urandom_range(0, 4));
                step("R6 R8 R9 random");
            end
        end
        finish_run();
    end

endmodule